// File: doc/BRIEF.md
# Single-Phase Grid Angle Tracker

This block recovers the electrical angle of a single-phase grid from one stream of voltage samples. The sample strobe must run at exactly 156 strobes per grid cycle. On every strobe the block uses the new sample as the in-phase (alpha) component. It uses the sample taken 39 strobes earlier, which is one quarter cycle back, as the orthogonal (beta) component. It rotates both into a frame that turns with its own angle estimate and drives the quadrature component of that frame toward zero. A proportional-integral regulator performs the correction by trimming the step of a phase accumulator around its nominal rate of one index per strobe.

The outputs are the angle as an index within one cycle (0 to 155), a cosine and a sine of that index in signed fixed point, the direct-axis component as a measure of voltage amplitude, and a flag that reports a held lock. The block suits converter control that needs a reference angle synchronised to the grid. Examples are current regulators that work in a rotating frame, or references for harmonic components, which share the same angle index.

Top module: `grid_angle_pll`

## Requirements
- R1: While reset is high and on the cycle after it, the angle index is 0, the amplitude output is 0 and the lock flag is low. Because the index is 0, the cosine output reads 16384 and the sine output reads 0.
- R2: In a cycle where `sampleValid` is low, the angle index, amplitude output and lock flag do not change, whatever `sampleIn` holds.
- R3: The angle index always lies in 0..155. With an all-zero input it advances by exactly one per strobe and wraps from 155 to 0.
- R4: For index k, the cosine and sine outputs equal round(16384*cos(2*pi*k/156)) and round(16384*sin(2*pi*k/156)), with a tolerance of 1 LSB.
- R5: The orthogonal component is the sample from exactly 39 strobes earlier. The amplitude output registered by a strobe is floor((alpha*cos + beta*sin)/16384), using the cosine and sine of the index before that strobe.
- R6: Reset clears the quarter-cycle delay store, so after reset the orthogonal component reads 0 for the first 39 strobes.
- R7: Let q = floor((beta*cos - alpha*sin)/16384). The lock flag rises on the 156th consecutive strobe with |q| < 768. It drops on the first strobe with |q| >= 768.
- R8: A sinusoid of amplitude 12000 at 156 samples per cycle drives the block into tracking. Once tracking, the angle index stays within 2 of the input's phase index, the amplitude output stays within 3% of 12000, and lock stays high.
- R9: The regulator correction is limited to plus or minus half a nominal step, so the angle index advances by 0, 1 or 2 per strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | One-cycle strobe marking a new voltage sample |
| sampleIn | input | 16 | Signed grid voltage sample |
| angleIdx | output | 8 | Angle estimate as index 0..155 within one cycle |
| cosOut | output | 16 | Cosine of the angle index, 16384 = 1.0 |
| sinOut | output | 16 | Sine of the angle index, 16384 = 1.0 |
| ampOut | output | 18 | Signed direct-axis component (voltage amplitude) |
| locked | output | 1 | Quadrature component has stayed small for a full cycle |

## Verification
The assertions assume that `sampleValid` is a single-cycle pulse separated by at least one idle cycle. They also assume that the strobe rate relates to the grid as exactly 156 strobes per cycle, since otherwise the 39-strobe delay is not a true quarter cycle. The assumption about the grid frequency is not checked, but the step and range properties hold for any input. The stimulus keeps within these bounds: every strobe is one clock wide and followed by an idle clock, and every tracked waveform is a sinusoid sampled at integer positions of the 156-point cycle with an amplitude well inside 16 bits. The impulse stimuli apply their nonzero sample when the angle sits on index 0. At that index the sine term is zero, so the quadrature error stays zero and the angle keeps its nominal sequence.

// File: rtl/grid_pll_pkg.sv
package grid_pll_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic step;   // accept the current sample and advance the loop
  } pllCtrl_t;
endpackage

// File: rtl/grid_pll_delay.sv
module grid_pll_delay #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 39
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);
  localparam int PTR_W = $clog2(DEPTH);

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;

  // Oldest entry sits where the next write lands
  assign dout = mem[wrPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (shift) begin
      mem[wrPtr] <= din;
      wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/grid_pll_trig.sv
module grid_pll_trig #(
  parameter int CYCLE_LEN = 156,
  parameter int TRIG_W    = 16,
  parameter int IDX_W     = 8
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [TRIG_W-1:0] cosVal,
  output logic signed [TRIG_W-1:0] sinVal
);
  function automatic logic signed [TRIG_W-1:0] tableEntry(int k, bit useSin);
    real ang, v, scaled;
    ang    = 2.0 * 3.14159265358979 * real'(k) / real'(CYCLE_LEN);
    v      = useSin ? $sin(ang) : $cos(ang);
    scaled = v * real'(1 << (TRIG_W - 2));
    return TRIG_W'($rtoi(scaled + ((scaled >= 0.0) ? 0.5 : -0.5)));
  endfunction

  logic signed [TRIG_W-1:0] cosTab [CYCLE_LEN];
  logic signed [TRIG_W-1:0] sinTab [CYCLE_LEN];

  for (genvar k = 0; k < CYCLE_LEN; k++) begin : g_tab
    assign cosTab[k] = tableEntry(k, 1'b0);
    assign sinTab[k] = tableEntry(k, 1'b1);
  end

  assign cosVal = cosTab[idx];
  assign sinVal = sinTab[idx];
endmodule

// File: rtl/grid_pll_datapath.sv
module grid_pll_datapath
  import grid_pll_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CYCLE_LEN = 156,
  parameter int TRIG_W    = 16,
  parameter int FRAC_W    = 16,
  parameter int KP_SHL    = 2,
  parameter int KI_SHR    = 4,
  parameter int LOCK_THR  = 768,
  parameter int IDX_W     = $clog2(CYCLE_LEN),
  parameter int DQ_W      = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pllCtrl_t                 ctrl,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic [IDX_W-1:0]         angleIdx,
  output logic signed [TRIG_W-1:0] cosOut,
  output logic signed [TRIG_W-1:0] sinOut,
  output logic signed [DQ_W-1:0]   ampOut,
  output logic                     qSmall
);
  localparam int QUARTER   = CYCLE_LEN / 4;
  localparam int ACC_W     = IDX_W + FRAC_W;
  localparam int MUL_W     = DATA_W + TRIG_W + 1;
  localparam int PI_W      = 32;
  localparam int TRIG_FRAC = TRIG_W - 2;
  localparam logic [ACC_W:0] MODULUS = (ACC_W + 1)'(CYCLE_LEN) << FRAC_W;
  localparam logic [ACC_W:0] NOMINAL = (ACC_W + 1)'(1) << FRAC_W;
  localparam logic signed [PI_W-1:0] LIMIT   = PI_W'(1 << (FRAC_W - 1));
  localparam logic signed [DQ_W-1:0] THR     = DQ_W'(LOCK_THR);

  logic [ACC_W-1:0]          phaseAcc;
  logic signed [PI_W-1:0]    integ;
  logic signed [DQ_W-1:0]    ampReg;
  logic signed [DATA_W-1:0]  beta;
  logic signed [TRIG_W-1:0]  cosVal, sinVal;
  logic signed [MUL_W-1:0]   dMul, qMul;
  logic signed [DQ_W-1:0]    dVal, qVal;
  logic signed [PI_W-1:0]    qExt, integNext, propTerm, piOut, incrS;
  logic [ACC_W:0]            phaseSum;
  logic [ACC_W-1:0]          phaseNext;

  function automatic logic signed [PI_W-1:0] clampPi(input logic signed [PI_W-1:0] v);
    if (v > LIMIT)  return LIMIT;
    if (v < -LIMIT) return -LIMIT;
    return v;
  endfunction

  grid_pll_delay #(.DATA_W(DATA_W), .DEPTH(QUARTER)) u_delay (
    .clk(clk), .rst(rst), .shift(ctrl.step), .din(sampleIn), .dout(beta)
  );

  grid_pll_trig #(.CYCLE_LEN(CYCLE_LEN), .TRIG_W(TRIG_W), .IDX_W(IDX_W)) u_trig (
    .idx(angleIdx), .cosVal(cosVal), .sinVal(sinVal)
  );

  assign angleIdx = phaseAcc[ACC_W-1:FRAC_W];

  // Rotation into the frame of the current estimate
  always_comb begin
    dMul = MUL_W'(sampleIn) * MUL_W'(cosVal) + MUL_W'(beta) * MUL_W'(sinVal);
    qMul = MUL_W'(beta) * MUL_W'(cosVal) - MUL_W'(sampleIn) * MUL_W'(sinVal);
    dVal = DQ_W'(dMul >>> TRIG_FRAC);
    qVal = DQ_W'(qMul >>> TRIG_FRAC);
    qSmall = (qVal < THR) && (qVal > -THR);
  end

  // PI regulator trimming the accumulator step
  always_comb begin
    qExt      = PI_W'(qVal);
    integNext = clampPi(integ + (qExt >>> KI_SHR));
    propTerm  = qExt <<< KP_SHL;
    piOut     = clampPi(propTerm + integNext);
    incrS     = $signed(PI_W'(NOMINAL)) + piOut;
    phaseSum  = {1'b0, phaseAcc} + (ACC_W + 1)'(incrS);
    phaseNext = (phaseSum >= MODULUS) ? ACC_W'(phaseSum - MODULUS) : ACC_W'(phaseSum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      integ    <= '0;
      ampReg   <= '0;
    end else if (ctrl.step) begin
      phaseAcc <= phaseNext;
      integ    <= integNext;
      ampReg   <= dVal;
    end
  end

  assign ampOut = ampReg;
  assign cosOut = cosVal;
  assign sinOut = sinVal;
endmodule

// File: rtl/grid_pll_ctrl.sv
module grid_pll_ctrl
  import grid_pll_pkg::*;
#(
  parameter int CYCLE_LEN = 156
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sampleValid,
  input  logic     qSmall,
  output pllCtrl_t ctrl,
  output logic     locked
);
  localparam int CNT_W = $clog2(CYCLE_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CYCLE_LEN);

  logic [CNT_W-1:0] quietCnt;

  assign ctrl.step = sampleValid;

  // Consecutive strobes with a small quadrature error, saturating at one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      quietCnt <= '0;
    end else if (sampleValid) begin
      if (!qSmall)               quietCnt <= '0;
      else if (quietCnt != FULL) quietCnt <= quietCnt + 1'b1;
    end
  end

  assign locked = (quietCnt == FULL);
endmodule

// File: rtl/grid_angle_pll.sv
module grid_angle_pll
  import grid_pll_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CYCLE_LEN = 156,
  parameter int TRIG_W    = 16,
  parameter int FRAC_W    = 16,
  parameter int KP_SHL    = 2,
  parameter int KI_SHR    = 4,
  parameter int LOCK_THR  = 768,
  parameter int IDX_W     = $clog2(CYCLE_LEN),
  parameter int DQ_W      = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic [IDX_W-1:0]         angleIdx,
  output logic signed [TRIG_W-1:0] cosOut,
  output logic signed [TRIG_W-1:0] sinOut,
  output logic signed [DQ_W-1:0]   ampOut,
  output logic                     locked
);
  pllCtrl_t ctrl;
  logic qSmall;

  grid_pll_ctrl #(.CYCLE_LEN(CYCLE_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .qSmall(qSmall),
    .ctrl(ctrl), .locked(locked)
  );

  grid_pll_datapath #(
    .DATA_W(DATA_W), .CYCLE_LEN(CYCLE_LEN), .TRIG_W(TRIG_W), .FRAC_W(FRAC_W),
    .KP_SHL(KP_SHL), .KI_SHR(KI_SHR), .LOCK_THR(LOCK_THR), .IDX_W(IDX_W), .DQ_W(DQ_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .sampleIn(sampleIn),
    .angleIdx(angleIdx), .cosOut(cosOut), .sinOut(sinOut), .ampOut(ampOut),
    .qSmall(qSmall)
  );
endmodule

// File: rtl/grid_pll_checker.sv
module grid_pll_checker #(
  parameter int DATA_W    = 16,
  parameter int CYCLE_LEN = 156,
  parameter int TRIG_W    = 16,
  parameter int IDX_W     = 8,
  parameter int DQ_W      = 18
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sampleValid,
  input logic signed [DATA_W-1:0] sampleIn,
  input logic [IDX_W-1:0]         angleIdx,
  input logic signed [TRIG_W-1:0] cosOut,
  input logic signed [TRIG_W-1:0] sinOut,
  input logic signed [DQ_W-1:0]   ampOut,
  input logic                     locked
);
  localparam int UNIT = 1 << (TRIG_W - 2);

  function automatic int stepOf(logic [IDX_W-1:0] cur, logic [IDX_W-1:0] prev);
    return (int'(cur) >= int'(prev)) ? int'(cur) - int'(prev)
                                     : int'(cur) + CYCLE_LEN - int'(prev);
  endfunction

  function automatic int absOf(logic signed [TRIG_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (angleIdx == '0 && ampOut == '0 && !locked)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !sampleValid |=> ($stable(angleIdx) && $stable(ampOut) && $stable(locked))); // R2
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst) int'(angleIdx) < CYCLE_LEN); // R3
  AST_TRIG_NORM: assert property (@(posedge clk) disable iff (rst) (absOf(cosOut) + absOf(sinOut) >= UNIT - 1) && (absOf(cosOut) + absOf(sinOut) <= (UNIT * 3) / 2)); // R4
  AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (rst) ($rose(locked) || $fell(locked)) |-> $past(sampleValid)); // R7
  AST_BOUNDED_STEP: assert property (@(posedge clk) disable iff (rst) sampleValid |=> (stepOf(angleIdx, $past(angleIdx)) <= 2)); // R9
endmodule

bind grid_angle_pll grid_pll_checker #(
  .DATA_W(DATA_W), .CYCLE_LEN(CYCLE_LEN), .TRIG_W(TRIG_W), .IDX_W(IDX_W), .DQ_W(DQ_W)
) u_chk (.*);

// File: tb/grid_angle_pll_test.sv
module grid_angle_pll_test;
  localparam int N  = 156;
  localparam int DW = 16;
  localparam int TW = 16;
  localparam int IW = 8;
  localparam int QW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic signed [DW-1:0] sampleIn = '0;
  logic [IW-1:0] angleIdx;
  logic signed [TW-1:0] cosOut, sinOut;
  logic signed [QW-1:0] ampOut;
  logic locked;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  grid_angle_pll uut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .angleIdx(angleIdx), .cosOut(cosOut), .sinOut(sinOut), .ampOut(ampOut),
    .locked(locked)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkWithin(string req, string what, longint act, longint lo, longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic int roundReal(real v);
    return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
  endfunction

  function automatic int refTrig(int k, bit useSin);
    real a;
    a = 2.0 * 3.14159265358979 * real'(k) / real'(N);
    return roundReal(16384.0 * (useSin ? $sin(a) : $cos(a)));
  endfunction

  function automatic int circDist(int a, int b);
    int d;
    d = ((a - b) % N + N) % N;
    return (d > N / 2) ? N - d : d;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b0;
    sampleIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One strobe; returns at the next falling edge with outputs updated
  task automatic strobe(input int v);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = DW'(v);
    @(negedge clk);
    sampleValid = 1'b0;
    sampleIn = '0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "index in reset", angleIdx, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "index after reset", angleIdx, 0);
    check("R1", "cos after reset", cosOut, 16384);
    check("R1", "sin after reset", sinOut, 0);
    check("R1", "amplitude after reset", ampOut, 0);
    check("R1", "lock after reset", locked, 0);
  endtask

  task automatic testZeroRun();
    int trigBad;
    trigBad = 0;
    doReset();
    for (int k = 1; k <= 160; k++) begin
      strobe(0);
      if (k == 1 || k == 78 || k == 155 || k == 160)
        check("R3", $sformatf("index after %0d zero strobes", k), angleIdx, k % N);
      if (k == 156) check("R3", "wrap from 155 to 0", angleIdx, 0);
      if (cosOut > refTrig(k % N, 1'b0) + 1 || cosOut < refTrig(k % N, 1'b0) - 1 ||
          sinOut > refTrig(k % N, 1'b1) + 1 || sinOut < refTrig(k % N, 1'b1) - 1) trigBad++;
      if (k == 155) check("R7", "lock after 155 quiet strobes", locked, 0);
      if (k == 156) check("R7", "lock after 156 quiet strobes", locked, 1);
    end
    check("R4", "trig entries off by more than 1 LSB", trigBad, 0);
    check("R4", "sin at index 39", sinOut >= 0 ? refTrig(39, 1'b1) : 0, 16384);
    // Index is 4: q = -30000*sin(idx4) is far beyond the threshold
    strobe(30000);
    check("R7", "lock drops on large quadrature error", locked, 0);
  endtask

  task automatic testIdleHold();
    logic [IW-1:0] idx0;
    logic signed [QW-1:0] amp0;
    doReset();
    strobe(5000);
    repeat (4) strobe(0);
    idx0 = angleIdx;
    amp0 = ampOut;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      sampleIn = DW'(1000 * c - 9000);
    end
    @(negedge clk);
    sampleIn = '0;
    check("R2", "index held without strobe", angleIdx, idx0);
    check("R2", "amplitude held without strobe", ampOut, amp0);
    check("R2", "lock held without strobe", locked, 0);
  endtask

  task automatic testQuarterDelay();
    int nonZero;
    nonZero = 0;
    doReset();
    strobe(10000);
    check("R5", "amplitude of impulse at index 0", ampOut, 10000);
    for (int j = 1; j <= 38; j++) begin
      strobe(0);
      if (ampOut != 0) nonZero++;
    end
    check("R5", "amplitude before delayed impulse", nonZero, 0);
    strobe(0);
    check("R5", "delayed impulse after 39 strobes", ampOut, 10000);
    strobe(0);
    check("R5", "amplitude one strobe later", ampOut, 0);
    check("R5", "index undisturbed", angleIdx, 41);
  endtask

  task automatic testRingClear();
    int nonZero;
    nonZero = 0;
    doReset();
    for (int j = 0; j < 50; j++) strobe(20000 - 700 * j);
    doReset();
    for (int j = 0; j < 45; j++) begin
      strobe(0);
      if (ampOut != 0) nonZero++;
    end
    check("R6", "stale delay content after reset", nonZero, 0);
    check("R6", "index after 45 zero strobes", angleIdx, 45);
  endtask

  task automatic testTracking();
    localparam int OFF = 40;
    localparam real AMP = 12000.0;
    int settle, idxBad, ampBad, lockBad, stepBad, prev, stepNow, expIdx, v;
    settle = 40 * N;
    idxBad = 0; ampBad = 0; lockBad = 0; stepBad = 0;
    doReset();
    prev = angleIdx;
    for (int n = 0; n < settle + N; n++) begin
      v = roundReal(AMP * $cos(2.0 * 3.14159265358979 * real'((n + OFF) % N) / real'(N)));
      strobe(v);
      stepNow = ((int'(angleIdx) - prev) % N + N) % N;
      if (stepNow > 2) stepBad++;
      prev = angleIdx;
      if (n >= settle) begin
        expIdx = (n + OFF + 1) % N;
        if (circDist(angleIdx, expIdx) > 2) idxBad++;
        if (ampOut < 11640 || ampOut > 12360) ampBad++;
        if (!locked) lockBad++;
      end
    end
    check("R8", "strobes with index off track", idxBad, 0);
    check("R8", "strobes with amplitude outside 3%", ampBad, 0);
    check("R8", "strobes without lock while tracking", lockBad, 0);
    check("R9", "strobes advancing more than 2", stepBad, 0);
    checkWithin("R8", "amplitude at end", ampOut, 11640, 12360);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testZeroRun();
    testIdleHold();
    testQuarterDelay();
    testRingClear();
    testTracking();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule